// File: doc/BRIEF.md
# External Bus Cycle Controller

This block turns one internal read or write request into a complete cycle on an external memory bus. A request carries a 20-bit address, a byte/word size flag, a direction and write data. The address is matched against a small, parameter-defined set of chip-select regions. The matching region sets the data width (8 or 16 bits) and whether address and data share the low lines of the address/data bus (multiplexed) or not (demultiplexed). That region's active-low chip-select is asserted for the cycle.

Every part of a cycle walks through the same fixed phase order: an address phase with the latch strobe high, an address hold phase, a data phase of `DATA_CYCLES` clocks with the read or write strobe low, and a recovery phase with the bus released. A word request to an 8-bit region becomes two back-to-back byte cycles. When the request is finished, a one-cycle done pulse returns the assembled read data. The bidirectional address/data bus is presented as a driven value, a per-byte output enable and a sampled input, so the pad ring can build the tri-state drivers.

Top module: `ext_bus_ctrl`

## Requirements
- R1: Region i matches when (address AND mask_i) equals base_i. The lowest-index matching region wins. Its `cs_n` bit is low during the address, hold and data phases and high otherwise. With no match, all `cs_n` bits stay high and the cycle uses 16-bit multiplexed mode.
- R2: Once a request is accepted in idle, each byte or word cycle runs one clock with `ale` high, one hold clock, `DATA_CYCLES` clocks with the strobe low, and one recovery clock. `req_ready` is high only in idle.
- R3: `bus_addr` holds the cycle's address from the address phase through recovery. A word access uses the address with bit 0 cleared.
- R4: In 16-bit demultiplexed mode, both lanes are driven only on writes, during the address, hold and data phases. They carry the write word, or the write byte copied to both lanes for a byte access. On reads both lanes are released.
- R5: In 16-bit multiplexed mode, both lanes drive `bus_addr[15:0]` during the address and hold phases. In the data phase they follow R4.
- R6: In 8-bit demultiplexed mode, the high lane drives `req_wdata[15:8]` of the current request throughout the address, hold and data phases. The low lane carries only data, driven on writes and released on reads.
- R7: In 8-bit multiplexed mode, the high lane drives `bus_addr[15:8]` during the address, hold and data phases. The low lane drives `bus_addr[7:0]` during the address and hold phases, then carries data.
- R8: On reads, the enable of every data-carrying lane is low before and during the strobe. `ad_in` is sampled on the last data-phase clock. A word read returns {high byte, low byte}. A byte read returns the addressed byte in bits 7:0, with bits 15:8 equal to zero. On a 16-bit bus, address bit 0 selects the lane.
- R9: A word access to an 8-bit region runs as two back-to-back byte cycles. The first uses the even address and moves bits 7:0. The second uses the odd address and moves bits 15:8. Both bytes travel on the low lane.
- R10: `done` is high for exactly one clock, in the clock after the final recovery phase. The bus is idle in that clock and `rdata` is valid.
- R11: `rd_n` and `wr_n` are never low together, and neither is low while `ale` is high.
- R12: During and after reset the block is idle: `ale` low, both strobes high, all `cs_n` high, `ad_oe` zero, `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 20 | Request address |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| req_ready | output | 1 | Block idle and able to accept |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Assembled read data |
| bus_addr | output | 20 | Dedicated external address bus |
| ad_out | output | 16 | Value driven on the address/data bus |
| ad_oe | output | 2 | Output enable per byte lane (bit 1 = high lane) |
| ad_in | input | 16 | Value sampled from the address/data bus |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| cs_n | output | NUM_CS | Active-low chip-selects |

## Verification
The bench drives a word access into each of the four modes and into an address range claimed by two regions. A priority error shows up as the wrong chip-select and the wrong lane pattern. Word accesses to 8-bit regions confirm the split. A design that skipped the second byte cycle, or used the odd address first, would show a wrong address and a missing strobe in the cycle-by-cycle comparison. Byte reads at odd addresses on the 16-bit bus catch a swapped lane select or a non-zero upper byte. The bench memory drives `ad_in` only while the read strobe is low, so a capture that happens after the strobe returns wrong read data. Reads are checked for released lanes during the strobe, which catches bus contention.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_ADDR    = 3'd1,
        PH_HOLD    = 3'd2,
        PH_DATA    = 3'd3,
        PH_RECOVER = 3'd4
    } phase_e;

    typedef struct packed {
        logic wide;   // 1 = 16-bit data path
        logic mux;    // 1 = address shares the low lanes
    } bus_mode_t;

endpackage

// File: rtl/ebc_region_decode.sv
module ebc_region_decode
    import ebc_pkg::*;
#(
    parameter int                       AW      = 20,
    parameter int                       NUM_CS  = 3,
    parameter logic [NUM_CS*AW-1:0]     CS_BASE = '0,
    parameter logic [NUM_CS*AW-1:0]     CS_MASK = '0,
    parameter logic [NUM_CS-1:0]        CS_WIDE = '0,
    parameter logic [NUM_CS-1:0]        CS_MUX  = '0
) (
    input  logic [AW-1:0]     addr,
    output logic [NUM_CS-1:0] hit,
    output bus_mode_t         mode
);

    logic [NUM_CS-1:0] raw_match;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_region
        assign raw_match[g] =
            ((addr & CS_MASK[g*AW +: AW]) == CS_BASE[g*AW +: AW]);
    end

    // Lowest index wins; no match falls back to 16-bit multiplexed.
    always_comb begin
        logic taken;
        taken     = 1'b0;
        hit       = '0;
        mode.wide = 1'b1;
        mode.mux  = 1'b1;
        for (int i = 0; i < NUM_CS; i++) begin
            if (raw_match[i] && !taken) begin
                taken     = 1'b1;
                hit[i]    = 1'b1;
                mode.wide = CS_WIDE[i];
                mode.mux  = CS_MUX[i];
            end
        end
    end

endmodule

// File: rtl/ebc_lane_drive.sv
module ebc_lane_drive
    import ebc_pkg::*;
#(
    parameter int AW     = 20,
    parameter int LANE_W = 8,
    localparam int DW    = 2 * LANE_W
) (
    input  phase_e            phase,
    input  bus_mode_t         mode,
    input  logic              write,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wide_data,   // data for the 16-bit lanes
    input  logic [LANE_W-1:0] byte_data,   // data for the low lane, 8-bit bus
    input  logic [LANE_W-1:0] hi_internal, // internal high byte, 8-bit demux
    output logic [DW-1:0]     ad_out,
    output logic [1:0]        ad_oe
);

    logic active;
    logic addr_phase;

    assign active     = (phase == PH_ADDR) || (phase == PH_HOLD) || (phase == PH_DATA);
    assign addr_phase = (phase == PH_ADDR) || (phase == PH_HOLD);

    always_comb begin
        ad_out = '0;
        ad_oe  = 2'b00;
        if (active) begin
            if (mode.wide) begin
                if (mode.mux && addr_phase) begin
                    ad_oe  = 2'b11;
                    ad_out = addr[DW-1:0];
                end else if (write) begin
                    ad_oe  = 2'b11;
                    ad_out = wide_data;
                end
            end else begin
                ad_oe[1]             = 1'b1;
                ad_out[DW-1:LANE_W]  = mode.mux ? addr[DW-1:LANE_W] : hi_internal;
                if (mode.mux && addr_phase) begin
                    ad_oe[0]             = 1'b1;
                    ad_out[LANE_W-1:0]   = addr[LANE_W-1:0];
                end else if (write) begin
                    ad_oe[0]             = 1'b1;
                    ad_out[LANE_W-1:0]   = byte_data;
                end
            end
        end
    end

endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int                   AW          = 20,
    parameter int                   LANE_W      = 8,
    parameter int                   NUM_CS      = 3,
    parameter int                   DATA_CYCLES = 2,
    parameter logic [NUM_CS*AW-1:0] CS_BASE     = {20'h20000, 20'h30000, 20'h00000},
    parameter logic [NUM_CS*AW-1:0] CS_MASK     = {20'hE0000, 20'hF0000, 20'hF0000},
    parameter logic [NUM_CS-1:0]    CS_WIDE     = 3'b001,
    parameter logic [NUM_CS-1:0]    CS_MUX      = 3'b100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [AW-1:0]     req_addr,
    input  logic [2*LANE_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [2*LANE_W-1:0] rdata,
    output logic [AW-1:0]     bus_addr,
    output logic [2*LANE_W-1:0] ad_out,
    output logic [1:0]        ad_oe,
    input  logic [2*LANE_W-1:0] ad_in,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [NUM_CS-1:0] cs_n
);

    localparam int DW    = 2 * LANE_W;
    localparam int CNT_W = (DATA_CYCLES > 1) ? $clog2(DATA_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_CYCLES - 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic              write;
        logic              word;
        logic              split;
        logic              part;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     wdata;
        logic [NUM_CS-1:0] sel;
        bus_mode_t         mode;
        logic [DW-1:0]     rdata;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_CS-1:0] dec_hit;
    bus_mode_t         dec_mode;
    logic              active;
    logic [DW-1:0]     wide_data;
    logic [LANE_W-1:0] byte_data;

    ebc_region_decode #(
        .AW      (AW),
        .NUM_CS  (NUM_CS),
        .CS_BASE (CS_BASE),
        .CS_MASK (CS_MASK),
        .CS_WIDE (CS_WIDE),
        .CS_MUX  (CS_MUX)
    ) i_decode (
        .addr (req_addr),
        .hit  (dec_hit),
        .mode (dec_mode)
    );

    assign wide_data = ctl_q.word ? ctl_q.wdata
                                  : {ctl_q.wdata[LANE_W-1:0], ctl_q.wdata[LANE_W-1:0]};
    assign byte_data = ctl_q.part ? ctl_q.wdata[DW-1:LANE_W] : ctl_q.wdata[LANE_W-1:0];

    ebc_lane_drive #(
        .AW     (AW),
        .LANE_W (LANE_W)
    ) i_lanes (
        .phase       (ctl_q.ph),
        .mode        (ctl_q.mode),
        .write       (ctl_q.write),
        .addr        (ctl_q.addr),
        .wide_data   (wide_data),
        .byte_data   (byte_data),
        .hi_internal (ctl_q.wdata[DW-1:LANE_W]),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    ctl_d.ph    = PH_ADDR;
                    ctl_d.write = req_write;
                    ctl_d.word  = req_word;
                    ctl_d.split = req_word && !dec_mode.wide;
                    ctl_d.part  = 1'b0;
                    ctl_d.addr  = req_word ? {req_addr[AW-1:1], 1'b0} : req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.sel   = dec_hit;
                    ctl_d.mode  = dec_mode;
                    if (!req_write) begin
                        ctl_d.rdata = '0;
                    end
                end
            end
            PH_ADDR: begin
                ctl_d.ph = PH_HOLD;
            end
            PH_HOLD: begin
                ctl_d.ph  = PH_DATA;
                ctl_d.cnt = '0;
            end
            PH_DATA: begin
                if (ctl_q.cnt == CNT_LAST) begin
                    ctl_d.ph = PH_RECOVER;
                    if (!ctl_q.write) begin
                        if (ctl_q.mode.wide) begin
                            if (ctl_q.word) begin
                                ctl_d.rdata = ad_in;
                            end else begin
                                ctl_d.rdata[LANE_W-1:0] = ctl_q.addr[0] ? ad_in[DW-1:LANE_W]
                                                                        : ad_in[LANE_W-1:0];
                            end
                        end else if (ctl_q.part) begin
                            ctl_d.rdata[DW-1:LANE_W] = ad_in[LANE_W-1:0];
                        end else begin
                            ctl_d.rdata[LANE_W-1:0] = ad_in[LANE_W-1:0];
                        end
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                end
            end
            PH_RECOVER: begin
                if (ctl_q.split && !ctl_q.part) begin
                    ctl_d.ph      = PH_ADDR;
                    ctl_d.part    = 1'b1;
                    ctl_d.addr[0] = 1'b1;
                end else begin
                    ctl_d.ph   = PH_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: begin
                ctl_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign active    = (ctl_q.ph == PH_ADDR) || (ctl_q.ph == PH_HOLD) || (ctl_q.ph == PH_DATA);
    assign req_ready = (ctl_q.ph == PH_IDLE);
    assign done      = ctl_q.done;
    assign rdata     = ctl_q.rdata;
    assign bus_addr  = ctl_q.addr;
    assign ale       = (ctl_q.ph == PH_ADDR);
    assign rd_n      = !((ctl_q.ph == PH_DATA) && !ctl_q.write);
    assign wr_n      = !((ctl_q.ph == PH_DATA) && ctl_q.write);
    assign cs_n      = ~(ctl_q.sel & {NUM_CS{active}});

endmodule

// File: rtl/ebc_bus_chk.sv
module ebc_bus_chk #(
    parameter int AW     = 20,
    parameter int DW     = 16,
    parameter int NUM_CS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic [AW-1:0]     bus_addr,
    input logic [1:0]        ad_oe,
    input logic              ale,
    input logic              rd_n,
    input logic              wr_n,
    input logic [NUM_CS-1:0] cs_n
);

    assert_single_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ale && rd_n && wr_n && (&cs_n) && ad_oe == 2'b00));

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !ale) |-> $stable(bus_addr));

    assert_read_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe[0]);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || wr_n));

    assert_ale_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

endmodule

bind ext_bus_ctrl ebc_bus_chk #(
    .AW     (AW),
    .DW     (2 * LANE_W),
    .NUM_CS (NUM_CS)
) i_ebc_bus_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .bus_addr  (bus_addr),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .cs_n      (cs_n)
);

// File: tb/test_ext_bus_ctrl.sv
module test_ext_bus_ctrl;

    localparam int DCYC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, done, ale, rd_n, wr_n;
    logic [15:0] rdata, ad_out, ad_in;
    logic [19:0] bus_addr;
    logic [1:0]  ad_oe;
    logic [2:0]  cs_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ext_bus_ctrl #(.DATA_CYCLES(DCYC)) i_ext_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata), .bus_addr(bus_addr),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n)
    );

    // Memory contents as a pure function of the byte address.
    function automatic logic [7:0] mem_b(input logic [19:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h5};
    endfunction

    // Region map seen by the bench: 0 -> cs0 16 demux, 3 -> cs1 8 demux,
    // 2 -> cs2 8 mux (also covers 3 but loses priority), others -> 16 mux.
    function automatic void region_of(input logic [19:0] a, output bit wide,
                                      output bit mux, output logic [2:0] csn);
        case (a[19:16])
            4'h0:    begin wide = 1; mux = 0; csn = 3'b110; end
            4'h3:    begin wide = 0; mux = 0; csn = 3'b101; end
            4'h2:    begin wide = 0; mux = 1; csn = 3'b011; end
            default: begin wide = 1; mux = 1; csn = 3'b111; end
        endcase
    endfunction

    // External device: drives the bus only while the read strobe is low.
    always_comb begin
        bit w, m;
        logic [2:0] c;
        region_of(bus_addr, w, m, c);
        if (!rd_n) begin
            if (w) ad_in = {mem_b(bus_addr | 20'h1), mem_b(bus_addr & ~20'h1)};
            else   ad_in = {8'hC3, mem_b(bus_addr)};
        end else begin
            ad_in = 16'hDEAD;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected {oe[1:0], ad[15:0]} for step k of one byte or word cycle.
    function automatic logic [17:0] exp_lanes(bit wide, bit mux, bit wr, bit wd, int k,
                                              logic [19:0] pa, logic [15:0] wdat, bit part);
        bit in_addr = (k < 2);
        logic [7:0] b = part ? wdat[15:8] : wdat[7:0];
        logic [15:0] w16 = wd ? wdat : {wdat[7:0], wdat[7:0]};
        if (k == DCYC + 2) return 18'h0;
        case ({wide, mux})
            2'b10: return wr ? {2'b11, w16} : 18'h0;
            2'b11: begin
                if (in_addr) return {2'b11, pa[15:0]};
                return wr ? {2'b11, w16} : 18'h0;
            end
            2'b00: return wr ? {2'b11, wdat[15:8], b} : {2'b10, wdat[15:8], 8'h00};
            default: begin
                if (in_addr) return {2'b11, pa[15:8], pa[7:0]};
                return wr ? {2'b11, pa[15:8], b} : {2'b10, pa[15:8], 8'h00};
            end
        endcase
    endfunction

    task automatic do_access(input bit wr, input bit wd, input logic [19:0] a,
                             input logic [15:0] wdat);
        bit wide, mux, split;
        logic [2:0] csn;
        logic [19:0] base;
        logic [15:0] exp_rd;
        string ltag;
        region_of(a, wide, mux, csn);
        split  = wd && !wide;
        base   = wd ? {a[19:1], 1'b0} : a;
        exp_rd = wd ? {mem_b(base | 20'h1), mem_b(base)} : {8'h00, mem_b(a)};
        ltag   = wide ? (mux ? "R5" : "R4") : (mux ? "R7" : "R6");

        chk(req_ready === 1'b1, "R2 ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = wdat;
        @(negedge clk);
        req_valid = 1'b0; req_addr = 20'hFFFFF; req_wdata = 16'h5A5A;
        for (int p = 0; p < (split ? 2 : 1); p++) begin
            logic [19:0] pa = split ? (base | 20'(p)) : base;
            for (int k = 0; k < DCYC + 3; k++) begin
                bit in_data = (k >= 2) && (k < DCYC + 2);
                bit in_rec  = (k == DCYC + 2);
                logic [17:0] e = exp_lanes(wide, mux, wr, wd, k, pa, wdat, p[0]);
                logic [15:0] msk = {{8{e[17]}}, {8{e[16]}}};
                chk(ale === (k == 0), "R2 ale", 32'(ale), 32'(k == 0));
                chk(rd_n === !(in_data && !wr), "R2 rd_n", 32'(rd_n), 32'(!(in_data && !wr)));
                chk(wr_n === !(in_data && wr), "R2 wr_n", 32'(wr_n), 32'(!(in_data && wr)));
                chk(req_ready === 1'b0 && done === 1'b0, "R2 busy", {req_ready, done}, 0);
                chk(cs_n === (in_rec ? 3'b111 : csn), "R1 cs_n", 32'(cs_n),
                    32'(in_rec ? 3'b111 : csn));
                chk(bus_addr === pa, split ? "R9 part address" : "R3 bus_addr",
                    32'(bus_addr), 32'(pa));
                chk(ad_oe === e[17:16], {ltag, " ad_oe"}, 32'(ad_oe), 32'(e[17:16]));
                chk((ad_out & msk) === (e[15:0] & msk), {ltag, " ad_out"},
                    32'(ad_out & msk), 32'(e[15:0] & msk));
                if (!wr && in_data)
                    chk(ad_oe[0] === 1'b0, "R8 lane released", 32'(ad_oe), 0);
                @(negedge clk);
            end
        end
        chk(done === 1'b1 && req_ready === 1'b1, "R10 done pulse", {done, req_ready}, 3);
        chk(ale === 1'b0 && rd_n && wr_n && cs_n === 3'b111, "R11 idle strobes",
            {ale, rd_n, wr_n, cs_n}, 32'b0_1_1_111);
        if (!wr)
            chk(rdata === exp_rd, split ? "R9 split read data" : "R8 read data",
                32'(rdata), 32'(exp_rd));
        @(negedge clk);
        chk(done === 1'b0, "R10 done one clock", 32'(done), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(req_ready === 1 && done === 0 && ale === 0, "R12 reset idle",
            {req_ready, done, ale}, 32'b100);
        chk(rd_n === 1 && wr_n === 1 && cs_n === 3'b111 && ad_oe === 2'b00,
            "R12 reset bus", {rd_n, wr_n, cs_n, ad_oe}, 32'b1_1_111_00);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1 && done === 0 && ad_oe === 2'b00, "R12 after reset",
            {req_ready, done, ad_oe}, 32'b1_0_00);

        // 16-bit demultiplexed (R4)
        do_access(1, 1, 20'h01235, 16'hBEEF);
        do_access(0, 1, 20'h0ABC6, 16'h0000);
        do_access(0, 0, 20'h00011, 16'h0000);
        do_access(0, 0, 20'h00010, 16'h0000);
        do_access(1, 0, 20'h00021, 16'h3377);
        // 8-bit demultiplexed, priority over the overlapping region (R1, R6, R9)
        do_access(1, 1, 20'h35678, 16'hCAFE);
        do_access(0, 1, 20'h3FFFE, 16'h9100);
        do_access(0, 0, 20'h30003, 16'h4400);
        // 8-bit multiplexed (R7, R9)
        do_access(1, 1, 20'h2A5A4, 16'h1234);
        do_access(0, 1, 20'h20F11, 16'h0000);
        do_access(1, 0, 20'h2C0DE, 16'h00AB);
        // unmapped: default 16-bit multiplexed, no chip-select (R1, R5)
        do_access(1, 1, 20'h13456, 16'h9876);
        do_access(0, 1, 20'hFFFF0, 16'h0000);
        do_access(0, 0, 20'h70005, 16'h0000);
        do_access(1, 0, 20'h8000E, 16'h00E1);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule